// File: doc/BRIEF.md
# Supply Protection Restart Sequencer

This block is the supervisory state machine of a primary-side switching supply controller. It decides, cycle by cycle, whether the PWM modulator may switch. It also decides whether the high-voltage startup current source charges the supply capacitor. It reads synchronous flags from analog comparators: the supply level against its turn-on, turn-off and latch-release thresholds, supply over-voltage, sense-pin over-voltage, over-temperature, and a low line-current flag.

Each raw fault flag is debounced over its own window, which is counted in clock cycles. An accepted fault stops switching and is sorted into one of two classes. Auto-restart faults (supply over-voltage, brownout) clear when the supply collapses to its turn-off level, so the supply retries on the next charge cycle. Latched faults (sense-pin over-voltage, over-temperature) survive the repeated charge/discharge hiccup. Switching stays off until the supply falls below the lower release level, which happens only once the supply is unplugged. A status code reports the first fault that tripped.

Top module: `supply_restart_seq`

## Requirements
- R1: While reset is held, and on the first cycle after reset, `startup_en` is 1, `pwm_en` is 0 and `fault_code` is 0.
- R2: When `vdd_above_on` is sampled while the startup source is on and no fault is held, the next cycle shows `pwm_en`=1 and `startup_en`=0.
- R3: When `vdd_below_off` is sampled, the next cycle shows `pwm_en`=0 and `startup_en`=1, whatever the fault state.
- R4: A raw fault flag is accepted only after it is sampled high on N consecutive clock edges, where N is that fault's window parameter. The fault is recorded at the following edge. A single low sample inside the window restarts the count.
- R5: `pwm_en` is 0 in the cycle after a fault is accepted, and `pwm_en` and `startup_en` are never both 1.
- R6: `fault_code` encodes 0 = none, 1 = supply over-voltage, 2 = brownout, 3 = sense-pin over-voltage, 4 = over-temperature. It holds the first accepted fault until that fault clears. If faults are accepted on the same edge, the priority is 4, then 3, then 1, then 2.
- R7: Codes 1 and 2 clear at the edge where `vdd_below_off` is sampled. The next turn-on then restarts switching.
- R8: Codes 3 and 4 are not cleared by `vdd_below_off`. The startup source still cycles on at turn-off and off at turn-on, but `pwm_en` stays 0.
- R9: Codes 3 and 4 clear at the edge where `vdd_below_release` is sampled.
- R10: The line-current flag counts toward brownout only while `pwm_en` is 1. Asserting it while switching is off has no effect.
- R11: Once a fault clears, a different fault whose flag is still debounced high is recorded on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_above_on | input | 1 | Supply has risen past the turn-on level |
| vdd_below_off | input | 1 | Supply has fallen to the turn-off level |
| vdd_below_release | input | 1 | Supply has fallen below the latch-release level |
| vdd_ovp_raw | input | 1 | Supply over-voltage comparator |
| vs_ovp_raw | input | 1 | Sense-pin over-voltage comparator |
| otp_raw | input | 1 | Over-temperature comparator |
| line_low_raw | input | 1 | On-time line current below the brownout level |
| startup_en | output | 1 | High-voltage startup source enable |
| pwm_en | output | 1 | PWM switching permitted |
| fault_code | output | 3 | First accepted fault, encoded per R6 |

## Verification
The assertions watch properties that must hold on every cycle. The two enables are never high together. Switching stops one cycle after any accepted fault. A held code stays stable unless its own clear condition is present. A latched code survives a turn-off sample. A debounce trip always follows a high raw sample. The bench scenarios show the rest. They sweep the pulse length of each raw flag across its window boundary, with a glitch inside a window. They check priority between faults accepted together, a fault that tripped after another and is picked up when the first clears, the full hiccup sequence for both fault classes, and a line-current flag raised while switching is off.

// File: rtl/srs_pkg.sv
// Package: fault code type and class helpers shared by the sequencer.
// Assumes codes 3 and above are the latched class.
package srs_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_VDD_OVP = 3'd1,
        FLT_BROWN   = 3'd2,
        FLT_VS_OVP  = 3'd3,
        FLT_OTP     = 3'd4
    } fault_e;

    localparam int unsigned NUM_FAULTS = 4;

    // Latched-class test used by the clear logic.
    function automatic logic is_latched(fault_e f);
        return (f == FLT_VS_OVP) || (f == FLT_OTP);
    endfunction

endpackage

// File: rtl/srs_debounce.sv
// Module: consecutive-sample debouncer.
// trip goes high once raw has been sampled high on WINDOW consecutive edges
// and stays high while raw stays high; any low sample restarts the count.
// Assumes raw is already synchronous to clk and WINDOW >= 1.
module srs_debounce #(
    parameter int unsigned WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic trip
);
    localparam int unsigned CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!raw)        cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign trip = (cnt_q == LIMIT);

    // R4
    trip_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(raw));
endmodule

// File: rtl/srs_fault_reg.sv
// Module: fault arbiter and holding register.
// Picks the highest-priority trip when nothing is held, holds it, and clears
// it on the supply threshold matching its class. Clear beats accept.
// Assumes trips come from debouncers and thresholds are synchronous flags.
module srs_fault_reg
    import srs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   trip_vdd_ovp,
    input  logic   trip_brown,
    input  logic   trip_vs_ovp,
    input  logic   trip_otp,
    input  logic   below_off,
    input  logic   below_release,
    output fault_e fault_q,
    output fault_e fault_d
);
    fault_e pick;
    logic   clear;

    // Priority pick among simultaneous trips: latched class first.
    always_comb begin
        if (trip_otp)          pick = FLT_OTP;
        else if (trip_vs_ovp)  pick = FLT_VS_OVP;
        else if (trip_vdd_ovp) pick = FLT_VDD_OVP;
        else if (trip_brown)   pick = FLT_BROWN;
        else                   pick = FLT_NONE;
    end

    // Class-dependent clear and next-value selection.
    always_comb begin
        clear = (fault_q != FLT_NONE) &&
                (is_latched(fault_q) ? below_release : below_off);
        if (clear)                   fault_d = FLT_NONE;
        else if (fault_q == FLT_NONE) fault_d = pick;
        else                         fault_d = fault_q;
    end

    // Holding register for the first accepted fault.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= FLT_NONE;
        else        fault_q <= fault_d;
    end

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q != FLT_NONE && !below_off && !below_release) |=> $stable(fault_q));
    // R8
    latched_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_latched(fault_q) && !below_release) |=> (fault_q == $past(fault_q)));
endmodule

// File: rtl/srs_phase.sv
// Module: startup/run phase tracker.
// Startup source is on from reset and after every turn-off sample; turn-on
// ends the startup phase and starts switching only when no fault is pending.
// Assumes fault_ok reflects the fault register's next value.
module srs_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on,
    input  logic below_off,
    input  logic fault_ok,
    output logic startup_q,
    output logic run_q
);
    // Phase transitions on supply thresholds and faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            startup_q <= 1'b1;
            run_q     <= 1'b0;
        end else if (below_off) begin
            startup_q <= 1'b1;
            run_q     <= 1'b0;
        end else if (startup_q && above_on) begin
            startup_q <= 1'b0;
            run_q     <= fault_ok;
        end else if (!fault_ok) begin
            run_q     <= 1'b0;
        end
    end

    // R3
    startup_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(startup_q) |-> $past(below_off));
endmodule

// File: rtl/supply_restart_seq.sv
// Module: supply protection restart sequencer (top).
// Debounces four fault flags, classifies them as auto-restart or latched,
// and drives the startup-source and PWM enables through the hiccup cycle.
// Assumes all inputs are synchronous to clk; windows are in clk cycles.
module supply_restart_seq
    import srs_pkg::*;
#(
    parameter int unsigned VDD_OVP_CYC = 35000,
    parameter int unsigned BROWN_CYC   = 2500000,
    parameter int unsigned VS_OVP_CYC  = 22500,
    parameter int unsigned OTP_CYC     = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_above_on,
    input  logic       vdd_below_off,
    input  logic       vdd_below_release,
    input  logic       vdd_ovp_raw,
    input  logic       vs_ovp_raw,
    input  logic       otp_raw,
    input  logic       line_low_raw,
    output logic       startup_en,
    output logic       pwm_en,
    output logic [2:0] fault_code
);
    // Index order: code-1 (vdd ovp, brownout, vs ovp, otp).
    localparam int unsigned WIN [NUM_FAULTS] = '{VDD_OVP_CYC, BROWN_CYC, VS_OVP_CYC, OTP_CYC};

    logic [NUM_FAULTS-1:0] raw;
    logic [NUM_FAULTS-1:0] trip;
    fault_e                fault_q;
    fault_e                fault_d;
    logic                  startup_q;
    logic                  run_q;

    // Gather raw flags; line current only means something while switching.
    assign raw = {otp_raw, vs_ovp_raw, line_low_raw & run_q, vdd_ovp_raw};

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_deb
        srs_debounce #(.WINDOW(WIN[g])) i_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw[g]),
            .trip  (trip[g])
        );
    end

    srs_fault_reg i_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .trip_vdd_ovp  (trip[0]),
        .trip_brown    (trip[1]),
        .trip_vs_ovp   (trip[2]),
        .trip_otp      (trip[3]),
        .below_off     (vdd_below_off),
        .below_release (vdd_below_release),
        .fault_q       (fault_q),
        .fault_d       (fault_d)
    );

    srs_phase i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_on  (vdd_above_on),
        .below_off (vdd_below_off),
        .fault_ok  (fault_d == FLT_NONE),
        .startup_q (startup_q),
        .run_q     (run_q)
    );

    assign startup_en = startup_q;
    assign pwm_en     = run_q;
    assign fault_code = fault_q;

    // R5
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(startup_en && pwm_en));
    // R5
    fault_stops_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q == FLT_NONE && (|trip)) |=> !pwm_en);
    // R2
    turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> $past(vdd_above_on));
endmodule

// File: tb/test_supply_restart_seq.sv
// Bench: sweeps each fault flag's pulse length across its window and walks
// the hiccup sequences; expected values computed from the requirements.
module test_supply_restart_seq;
    localparam int W_VDD = 4;
    localparam int W_BO  = 5;
    localparam int W_VS  = 3;
    localparam int W_OT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdd_above_on = 0, vdd_below_off = 0, vdd_below_release = 0;
    logic vdd_ovp_raw = 0, vs_ovp_raw = 0, otp_raw = 0, line_low_raw = 0;
    logic startup_en, pwm_en;
    logic [2:0] fault_code;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    supply_restart_seq #(
        .VDD_OVP_CYC(W_VDD), .BROWN_CYC(W_BO), .VS_OVP_CYC(W_VS), .OTP_CYC(W_OT)
    ) i_supply_restart_seq (
        .clk(clk), .rst_n(rst_n),
        .vdd_above_on(vdd_above_on), .vdd_below_off(vdd_below_off),
        .vdd_below_release(vdd_below_release),
        .vdd_ovp_raw(vdd_ovp_raw), .vs_ovp_raw(vs_ovp_raw),
        .otp_raw(otp_raw), .line_low_raw(line_low_raw),
        .startup_en(startup_en), .pwm_en(pwm_en), .fault_code(fault_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_raw(input int idx, input logic v);
        case (idx)
            1: vdd_ovp_raw  = v;
            2: line_low_raw = v;
            3: vs_ovp_raw   = v;
            default: otp_raw = v;
        endcase
    endtask

    function automatic int win_of(input int idx);
        case (idx)
            1: return W_VDD;
            2: return W_BO;
            3: return W_VS;
            default: return W_OT;
        endcase
    endfunction

    // Full unplug/replug: release clears everything, then turn on.
    task automatic power_cycle();
        vdd_below_off = 1; vdd_below_release = 1; step(1);
        vdd_below_off = 0; vdd_below_release = 0;
        vdd_above_on = 1; step(1);
        vdd_above_on = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        chk("R1 startup", startup_en, 1);
        chk("R1 pwm", pwm_en, 0);
        chk("R1 code", fault_code, 0);
        rst_n = 1; step(1);
        chk("R1 startup after", startup_en, 1);
        chk("R1 code after", fault_code, 0);

        // R2: turn-on
        vdd_above_on = 1; step(1); vdd_above_on = 0;
        chk("R2 pwm", pwm_en, 1);
        chk("R2 startup", startup_en, 0);

        // R4/R6 sweep: every fault, every pulse length around its window
        for (int f = 1; f <= 4; f++) begin
            for (int len = 1; len <= win_of(f) + 1; len++) begin
                power_cycle();
                set_raw(f, 1); step(len); set_raw(f, 0); step(1);
                chk("R4 code", fault_code, (len >= win_of(f)) ? f : 0);
                chk("R5 pwm", pwm_en, (len >= win_of(f)) ? 0 : 1);
            end
        end

        // R4: low sample inside window restarts count
        power_cycle();
        vdd_ovp_raw = 1; step(W_VDD - 1); vdd_ovp_raw = 0; step(1);
        vdd_ovp_raw = 1; step(W_VDD - 1); vdd_ovp_raw = 0; step(1);
        chk("R4 glitch restart", fault_code, 0);
        chk("R4 glitch pwm", pwm_en, 1);

        // R5: pwm drops exactly one edge after acceptance
        power_cycle();
        vdd_ovp_raw = 1; step(W_VDD);
        chk("R5 before accept", pwm_en, 1);
        step(1);
        chk("R5 after accept", pwm_en, 0);
        chk("R5 no startup", startup_en, 0);

        // R7: auto class clears on turn-off, restarts at turn-on
        vdd_ovp_raw = 0;
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        chk("R7 cleared", fault_code, 0);
        chk("R3 startup on", startup_en, 1);
        vdd_above_on = 1; step(1); vdd_above_on = 0;
        chk("R7 restart pwm", pwm_en, 1);

        // R6: simultaneous latched trips -> OTP wins
        power_cycle();
        otp_raw = 1; vs_ovp_raw = 1; step(W_OT + 1);
        otp_raw = 0; vs_ovp_raw = 0;
        chk("R6 priority", fault_code, 4);

        // R8: latched survives hiccup
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        chk("R8 code kept", fault_code, 4);
        chk("R8 startup on", startup_en, 1);
        chk("R3 pwm off", pwm_en, 0);
        vdd_above_on = 1; step(1); vdd_above_on = 0;
        chk("R8 startup off", startup_en, 0);
        chk("R8 pwm stays off", pwm_en, 0);
        chk("R8 code still", fault_code, 4);

        // R9: release clears latched
        vdd_below_off = 1; vdd_below_release = 1; step(1);
        vdd_below_off = 0; vdd_below_release = 0;
        chk("R9 cleared", fault_code, 0);
        vdd_above_on = 1; step(1); vdd_above_on = 0;
        chk("R9 pwm resumes", pwm_en, 1);

        // R6/R11: first fault held, second picked up after clear
        power_cycle();
        vdd_ovp_raw = 1; step(W_VDD + 1); vdd_ovp_raw = 0;
        otp_raw = 1; step(W_OT + 2);
        chk("R6 first held", fault_code, 1);
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        chk("R11 cleared edge", fault_code, 0);
        step(1);
        chk("R11 second recorded", fault_code, 4);
        otp_raw = 0;

        // R10: line flag ignored while switching off
        power_cycle();
        vdd_below_off = 1; step(1); vdd_below_off = 0;
        line_low_raw = 1; step(W_BO * 3); line_low_raw = 0;
        chk("R10 code", fault_code, 0);
        vdd_above_on = 1; step(1); vdd_above_on = 0;
        chk("R10 pwm", pwm_en, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule